// File: doc/BRIEF.md
# Predicated Token Steering Unit

This block steers tokens from several producers onto one consumer using valid/ready channels, all on one clock. Each producer channel is paired with a one-bit predicate channel. A gate stage waits until it holds both a data token and a predicate token. A true predicate makes the token a candidate for the shared output. A false predicate drops the token: both inputs are consumed and nothing is sent downstream.

Surviving candidates meet in a merge stage. When several are present together, a fixed priority picks the lowest-numbered source, and the others see ready low and keep their tokens. The chosen token goes into a one-entry output register, which holds its value steady under back-pressure. The register can be emptied and refilled in the same cycle, so a steady stream runs at one token per clock. This lets successive loop iterations overlap. The output also reports which source the token came from.

Top module: `steer_fabric`

## Requirements
- R1: After a synchronous active-low reset, out_valid is low and no token is held. A reset asserted while a token waits in the output register discards that token.
- R2: A source whose data and predicate are both valid, with predicate bit 1, is consumed when it wins the merge and the output register can accept. Its data shows on out_data with out_valid high after the next rising edge, and out_src gives the source number as an unsigned binary index.
- R3: A source whose data and predicate are both valid, with predicate bit 0, asserts src_ready and pred_ready for that source in the same cycle. This holds whatever out_ready and the output register state are. No output token results, and a token already held at the output is not changed.
- R4: A source never asserts src_ready unless its predicate is valid, and never asserts pred_ready unless its data is valid.
- R5: When several sources present a true predicate in the same cycle, the lowest-numbered one is consumed, and the others see src_ready and pred_ready low.
- R6: While out_valid is high and out_ready is low, out_valid, out_data and out_src stay unchanged, and no true-predicate source is accepted.
- R7: In a cycle where a held token is taken (out_ready high), a new true-predicate token can be accepted in the same cycle. A continuous stream therefore delivers one token per clock.
- R8: Tokens from one source leave the output in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_valid | input | NSRC | Data token valid, one bit per source |
| src_data | input | NSRC*WIDTH | Data tokens; source i occupies bits [i*WIDTH +: WIDTH] |
| src_ready | output | NSRC | Data token consumed, one bit per source |
| pred_valid | input | NSRC | Predicate token valid, one bit per source |
| pred_bit | input | NSRC | Predicate value: 1 forwards, 0 drops |
| pred_ready | output | NSRC | Predicate token consumed, one bit per source |
| out_valid | output | 1 | Output token present |
| out_data | output | WIDTH | Output token data |
| out_src | output | IDXW | Index of the source that produced the output token |
| out_ready | input | 1 | Consumer accepts the output token |

## Verification
An output register that wrongly believes it is full stalls every true-predicate source. src_ready stays low in the same cycle, even though out_valid and out_ready would allow acceptance. A register that wrongly believes it is empty overwrites a stalled token, and the change to out_data is visible one edge later. A gate that fires on half a token shows src_ready without pred_ready, or the reverse, in the cycle of the fault. A priority error shows as a wrong out_src one edge after a multi-source cycle.

// File: rtl/steer_pkg.sv
// Shared helpers for the token steering unit.
// Assumes source counts of at most 32.
package steer_pkg;

    localparam int unsigned STEER_MAX_SRC = 32;

    // Keep only the lowest set bit of a request vector.
    function automatic logic [STEER_MAX_SRC-1:0] lowest_set(input logic [STEER_MAX_SRC-1:0] v);
        return v & (~v + 1'b1);
    endfunction

endpackage

// File: rtl/steer_gate.sv
// Predicated gate for one source.
// Fires only when a data token and a predicate token are both valid.
// A true predicate offers the data downstream, and both inputs are consumed when
// downstream accepts. A false predicate consumes both inputs at once and emits nothing.
// Assumes upstream holds each channel stable until it is consumed. The stage is
// purely combinational; clk and rst_n serve the local checks.
module steer_gate #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             d_valid,
    input  logic [WIDTH-1:0] d_data,
    output logic             d_ready,
    input  logic             p_valid,
    input  logic             p_bit,
    output logic             p_ready,
    output logic             q_valid,
    output logic [WIDTH-1:0] q_data,
    input  logic             q_ready
);

    logic pair_here;
    logic drop_now;
    logic pass_now;

    // Decide firing: a pair is present, then either drop it or hand it over.
    always_comb begin
        pair_here = d_valid & p_valid;
        drop_now  = pair_here & ~p_bit;
        pass_now  = pair_here & p_bit & q_ready;
        q_valid   = pair_here & p_bit;
        q_data    = d_data;
        d_ready   = drop_now | pass_now;
        p_ready   = drop_now | pass_now;
    end

    // R4: data is never taken without a predicate, and the reverse.
    a_r4_pair_only: assert property (@(posedge clk) disable iff (!rst_n)
        (d_ready || p_ready) |-> (d_valid && p_valid));

    // R3: a false predicate consumes both channels and offers nothing.
    a_r3_drop_free: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && p_valid && !p_bit) |-> (d_ready && p_ready && !q_valid));

endmodule

// File: rtl/steer_pick.sv
// Fixed-priority merge of the gate outputs.
// Grants the lowest-numbered requester when the output register can accept.
// Forwards the winner's data and index.
// Assumes NSRC is at most 32 and requests come from the gate stage.
module steer_pick #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned NSRC  = 3,
    localparam int unsigned IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NSRC-1:0]       req,
    input  logic [NSRC*WIDTH-1:0] req_data,
    input  logic                  sink_ready,
    output logic [NSRC-1:0]       grant,
    output logic                  win_valid,
    output logic [WIDTH-1:0]      win_data,
    output logic [IDXW-1:0]       win_idx
);

    import steer_pkg::*;

    logic [STEER_MAX_SRC-1:0] req_wide;
    logic [STEER_MAX_SRC-1:0] first_wide;
    logic [NSRC-1:0]          first;

    // Isolate the lowest requester and qualify it with downstream space.
    always_comb begin
        req_wide   = '0;
        req_wide[NSRC-1:0] = req;
        first_wide = lowest_set(req_wide);
        first      = first_wide[NSRC-1:0];
        grant      = first & {NSRC{sink_ready}};
        win_valid  = |req;
    end

    // Encode the winner's index and select its data.
    always_comb begin
        win_idx  = '0;
        win_data = '0;
        for (int i = 0; i < int'(NSRC); i++) begin
            if (first[i]) begin
                win_idx  = IDXW'(i);
                win_data = req_data[i*WIDTH +: WIDTH];
            end
        end
    end

    // R5: at most one source is granted per cycle.
    a_r5_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R5: no granted source has a lower-numbered requester.
    a_r5_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |-> ((req & (grant - 1'b1)) == '0));

endmodule

// File: rtl/steer_slot.sv
// One-entry output register with same-cycle drain and refill.
// Holds data and tag steady while the consumer stalls.
// Assumes in_data and in_tag are meaningful only when in_valid is high.
module steer_slot #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned TAGW  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_data,
    input  logic [TAGW-1:0]  in_tag,
    output logic             in_ready,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_data,
    output logic [TAGW-1:0]  out_tag,
    input  logic             out_ready
);

    logic             full_q;
    logic [WIDTH-1:0] data_q;
    logic [TAGW-1:0]  tag_q;

    // Space exists when empty, or when the held token leaves this cycle.
    always_comb begin
        in_ready  = ~full_q | out_ready;
        out_valid = full_q;
        out_data  = data_q;
        out_tag   = tag_q;
    end

    // Track occupancy: fill on accept, empty on drain with no refill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
        end else if (in_valid && in_ready) begin
            full_q <= 1'b1;
        end else if (out_ready) begin
            full_q <= 1'b0;
        end
    end

    // Capture payload on accept only.
    always_ff @(posedge clk) begin
        if (in_valid && in_ready) begin
            data_q <= in_data;
            tag_q  <= in_tag;
        end
    end

    // R6: a stalled token keeps its value and tag.
    a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_tag)));

    // R7: an offered token with space present is held after the edge.
    a_r7_fill_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

endmodule

// File: rtl/steer_fabric.sv
// Predicated multi-source token steering unit.
// One gate per source drops or offers tokens under its predicate. A fixed-priority
// merge selects one offer, and a one-entry register drives the single output.
// Assumes 1 <= NSRC <= 32 and producers that hold their channels until consumed.
module steer_fabric #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned NSRC  = 3,
    localparam int unsigned IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NSRC-1:0]       src_valid,
    input  logic [NSRC*WIDTH-1:0] src_data,
    output logic [NSRC-1:0]       src_ready,
    input  logic [NSRC-1:0]       pred_valid,
    input  logic [NSRC-1:0]       pred_bit,
    output logic [NSRC-1:0]       pred_ready,
    output logic                  out_valid,
    output logic [WIDTH-1:0]      out_data,
    output logic [IDXW-1:0]       out_src,
    input  logic                  out_ready
);

    logic [NSRC-1:0]       offer;
    logic [NSRC*WIDTH-1:0] offer_data;
    logic [NSRC-1:0]       grant;
    logic                  win_valid;
    logic [WIDTH-1:0]      win_data;
    logic [IDXW-1:0]       win_idx;
    logic                  slot_ready;

    // One predicated gate per source.
    for (genvar g = 0; g < int'(NSRC); g++) begin : g_gate
        steer_gate #(.WIDTH(WIDTH)) u_gate (
            .clk     (clk),
            .rst_n   (rst_n),
            .d_valid (src_valid[g]),
            .d_data  (src_data[g*WIDTH +: WIDTH]),
            .d_ready (src_ready[g]),
            .p_valid (pred_valid[g]),
            .p_bit   (pred_bit[g]),
            .p_ready (pred_ready[g]),
            .q_valid (offer[g]),
            .q_data  (offer_data[g*WIDTH +: WIDTH]),
            .q_ready (grant[g])
        );
    end

    steer_pick #(.WIDTH(WIDTH), .NSRC(NSRC)) u_pick (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (offer),
        .req_data   (offer_data),
        .sink_ready (slot_ready),
        .grant      (grant),
        .win_valid  (win_valid),
        .win_data   (win_data),
        .win_idx    (win_idx)
    );

    steer_slot #(.WIDTH(WIDTH), .TAGW(IDXW)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (win_valid),
        .in_data   (win_data),
        .in_tag    (win_idx),
        .in_ready  (slot_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_tag   (out_src),
        .out_ready (out_ready)
    );

    // R2: any consumed true-predicate token appears at the output next cycle.
    a_r2_forward_lands: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_ready & pred_ready & pred_bit) != '0) |=> out_valid);

    // R6: nothing with a true predicate is taken while the output is stalled.
    a_r6_no_take_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> ((src_ready & pred_bit) == '0));

endmodule

// File: tb/test_steer_fabric.sv
`timescale 1ns/1ps
module test_steer_fabric;

    localparam int unsigned WIDTH = 16;
    localparam int unsigned NSRC  = 3;
    localparam int unsigned IDXW  = 2;
    localparam int NVEC = 10;

    // Fields: [17:15] src_valid, [14:12] pred_valid, [11:9] pred_bit,
    // [8:6] expected src_ready, [5:3] expected pred_ready,
    // [2] expected out_valid, [1:0] expected out_src
    localparam logic [17:0] VEC [NVEC] = '{
        {3'b001, 3'b001, 3'b001, 3'b001, 3'b001, 1'b1, 2'd0},
        {3'b010, 3'b010, 3'b000, 3'b010, 3'b010, 1'b0, 2'd0},
        {3'b011, 3'b011, 3'b011, 3'b001, 3'b001, 1'b1, 2'd0},
        {3'b110, 3'b110, 3'b110, 3'b010, 3'b010, 1'b1, 2'd1},
        {3'b111, 3'b111, 3'b110, 3'b011, 3'b011, 1'b1, 2'd1},
        {3'b001, 3'b000, 3'b001, 3'b000, 3'b000, 1'b0, 2'd0},
        {3'b000, 3'b100, 3'b100, 3'b000, 3'b000, 1'b0, 2'd0},
        {3'b100, 3'b100, 3'b100, 3'b100, 3'b100, 1'b1, 2'd2},
        {3'b111, 3'b111, 3'b000, 3'b111, 3'b111, 1'b0, 2'd0},
        {3'b101, 3'b101, 3'b101, 3'b001, 3'b001, 1'b1, 2'd0}
    };

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [NSRC-1:0]       src_valid = '0;
    logic [NSRC*WIDTH-1:0] src_data = '0;
    logic [NSRC-1:0]       src_ready;
    logic [NSRC-1:0]       pred_valid = '0;
    logic [NSRC-1:0]       pred_bit = '0;
    logic [NSRC-1:0]       pred_ready;
    logic                  out_valid;
    logic [WIDTH-1:0]      out_data;
    logic [IDXW-1:0]       out_src;
    logic                  out_ready = 1'b1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    steer_fabric #(.WIDTH(WIDTH), .NSRC(NSRC)) i_steer_fabric (
        .clk(clk), .rst_n(rst_n),
        .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
        .pred_valid(pred_valid), .pred_bit(pred_bit), .pred_ready(pred_ready),
        .out_valid(out_valid), .out_data(out_data), .out_src(out_src),
        .out_ready(out_ready)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic clear_inputs();
        src_valid  = '0;
        pred_valid = '0;
        pred_bit   = '0;
    endtask

    function automatic logic [WIDTH-1:0] vec_word(input int v, input int s);
        return WIDTH'(16'h1000 * (s + 1) + v);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 out_valid in reset", 32'(out_valid), 32'd0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R1 out_valid after reset", 32'(out_valid), 32'd0);
        chk("R4 idle src_ready", 32'(src_ready), 32'd0);

        // Table walk: each vector starts with an empty output register.
        for (int v = 0; v < NVEC; v++) begin
            logic [17:0] e;
            e = VEC[v];
            src_valid  = e[17:15];
            pred_valid = e[14:12];
            pred_bit   = e[11:9];
            for (int s = 0; s < int'(NSRC); s++) src_data[s*WIDTH +: WIDTH] = vec_word(v, s);
            out_ready = 1'b1;
            #1;
            chk($sformatf("R3/R4/R5 src_ready vec %0d", v), 32'(src_ready), 32'(e[8:6]));
            chk($sformatf("R3/R4/R5 pred_ready vec %0d", v), 32'(pred_ready), 32'(e[5:3]));
            @(posedge clk);
            @(negedge clk);
            chk($sformatf("R2 out_valid vec %0d", v), 32'(out_valid), 32'(e[2]));
            if (e[2]) begin
                chk($sformatf("R2/R5 out_src vec %0d", v), 32'(out_src), 32'(e[1:0]));
                chk($sformatf("R2 out_data vec %0d", v), 32'(out_data), 32'(vec_word(v, int'(e[1:0]))));
            end
            clear_inputs();
            @(posedge clk);
            @(negedge clk);
        end

        // R6 and R3: back-pressure with a held token and a drop while stalled
        out_ready = 1'b0;
        src_valid[0] = 1'b1; pred_valid[0] = 1'b1; pred_bit[0] = 1'b1;
        src_data[0 +: WIDTH] = 16'hB0B0;
        @(posedge clk);
        @(negedge clk);
        clear_inputs();
        src_valid[1] = 1'b1; pred_valid[1] = 1'b1; pred_bit[1] = 1'b1;
        src_data[WIDTH +: WIDTH] = 16'hC1C1;
        src_valid[2] = 1'b1; pred_valid[2] = 1'b1; pred_bit[2] = 1'b0;
        src_data[2*WIDTH +: WIDTH] = 16'hD2D2;
        #1;
        chk("R6 stalled source blocked", 32'(src_ready[1]), 32'd0);
        chk("R3 drop under stall src_ready", 32'(src_ready[2]), 32'd1);
        chk("R3 drop under stall pred_ready", 32'(pred_ready[2]), 32'd1);
        @(posedge clk);
        @(negedge clk);
        src_valid[2] = 1'b0; pred_valid[2] = 1'b0;
        chk("R3/R6 held data after drop", 32'(out_data), 32'h0000B0B0);
        chk("R6 held valid", 32'(out_valid), 32'd1);
        @(posedge clk);
        @(negedge clk);
        chk("R6 held data second cycle", 32'(out_data), 32'h0000B0B0);
        chk("R6 held src", 32'(out_src), 32'd0);
        out_ready = 1'b1;
        #1;
        chk("R7 refill while draining", 32'(src_ready[1]), 32'd1);
        @(posedge clk);
        @(negedge clk);
        clear_inputs();
        chk("R7 refilled data", 32'(out_data), 32'h0000C1C1);
        chk("R7 refilled src", 32'(out_src), 32'd1);
        @(posedge clk);
        @(negedge clk);
        chk("R7 drained", 32'(out_valid), 32'd0);

        // R7 and R8: one token per clock from a single source, in order
        for (int k = 0; k < 6; k++) begin
            src_valid[0] = 1'b1; pred_valid[0] = 1'b1; pred_bit[0] = 1'b1;
            src_data[0 +: WIDTH] = WIDTH'(16'h5000 + k);
            @(posedge clk);
            @(negedge clk);
            chk($sformatf("R7 stream valid %0d", k), 32'(out_valid), 32'd1);
            chk($sformatf("R8 stream order %0d", k), 32'(out_data), 32'(16'h5000 + k));
        end
        clear_inputs();
        @(posedge clk);
        @(negedge clk);

        // R1: reset while a token is held
        out_ready = 1'b0;
        src_valid[1] = 1'b1; pred_valid[1] = 1'b1; pred_bit[1] = 1'b1;
        src_data[WIDTH +: WIDTH] = 16'hE3E3;
        @(posedge clk);
        @(negedge clk);
        clear_inputs();
        chk("R1 token held before reset", 32'(out_valid), 32'd1);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1 reset discards token", 32'(out_valid), 32'd0);
        rst_n = 1'b1;
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R1 stays empty after reset", 32'(out_valid), 32'd0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule